// File: doc/BRIEF.md
# Stereo Input Level Tag Encoder

This block grades the level of every converted stereo sample against digital full scale and reports the grade as a two-bit code on one serial pin. The samples arrive before clipping, as 20-bit signed words with full scale at 32768, together with one strobe per channel. The code for a channel is shifted out during that channel's half of the left/right frame clock, most significant bit first. A receiver samples it with the same bit clock it uses for the audio data.

The grade is one of four bands, in rising order of level:
- code 00: more than 1 dB under full scale.
- code 01: up to 1 dB under full scale.
- code 10: up to 1 dB over full scale.
- code 11: more than 1 dB over full scale.

No peak is held. Each new sample replaces the stored grade of its channel. The grade is captured when the half-frame begins, so a sample that arrives while a code is being shifted out does not disturb that code. The frame and bit clocks are sampled by the system clock, and only their edges are used.

Top module: `tag_overrange_encoder`

## Requirements
- R1: While `rst_ni` is low, `tag_o` is low. After reset, each channel's stored code is 00 until a sample for that channel arrives.
- R2: A sample whose magnitude is below 29205 is graded 00.
- R3: A magnitude from 29205 up to and including 32768 is graded 01.
- R4: A magnitude from 32769 up to and including 36766 is graded 10.
- R5: A magnitude above 36766 is graded 11. This includes the most negative input -524288, whose magnitude is formed without overflow.
- R6: Negative samples are graded by magnitude, so -x and +x give the same code.
- R7: Each code is sent as two bits, bit 1 first and then bit 0.
- R8: A low `lrck_i` marks the left half-frame, which carries the left code. A high `lrck_i` marks the right half-frame, which carries the right code. A falling `lrck_i` starts a frame.
- R9: Bit 1 is launched on the first falling `bclk_i` edge after the `lrck_i` transition; a falling edge coincident with the transition does not count. Bit 0 follows on the next falling edge. The pin returns low on the falling edge after that. `tag_o` changes only at falling `bclk_i` edges or at an `lrck_i` transition, so each bit is held for a full bit-clock period.
- R10: The grade is not sticky. When several samples for a channel arrive before its half-frame begins, only the last one sets the code.
- R11: The code is captured at the `lrck_i` transition that opens the half-frame. A strobe that arrives while that code is being shifted out does not change the bits on the pin. It takes effect in that channel's next half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples every other input |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | 20 | Signed pre-clip sample, two's complement |
| left_stb_i | input | 1 | One-cycle strobe: `sample_i` is a left sample |
| right_stb_i | input | 1 | One-cycle strobe: `sample_i` is a right sample |
| lrck_i | input | 1 | Left/right frame clock; low marks the left half |
| bclk_i | input | 1 | Serial bit clock; the tag launches on its falling edge |
| tag_o | output | 1 | Serial level tag, bit 1 first |

## Verification
A wrong band boundary or a wrong magnitude computation shows up as a wrong two-bit code on the pin in the very next half-frame for that channel. The bench therefore probes each threshold and its neighbour, for both signs and for the extreme codes. A sequencer state that is off by one shows up as bits shifted by one bit-clock period, or as a bit that changes within a period, within the same half-frame. The bench samples every bit slot twice to catch both. A stored code that is not replaced, or not snapshotted, shows up one frame later as a stale code or as a corrupted right-channel tag.

// File: rtl/tag_pkg.sv
package tag_pkg;

  typedef enum logic [1:0] {
    BAND_LOW  = 2'b00,
    BAND_NEAR = 2'b01,
    BAND_OVER = 2'b10,
    BAND_CLIP = 2'b11
  } band_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_ARMED = 2'b01,
    S_MSB   = 2'b10,
    S_LSB   = 2'b11
  } ser_state_e;

endpackage

// File: rtl/tag_reset_sync.sv
module tag_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/tag_edge_detect.sv
module tag_edge_detect #(
  parameter int NUM    = 2,
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] async_i,
  output logic [NUM-1:0] level_o,
  output logic [NUM-1:0] toggle_o
);

  for (genvar g = 0; g < NUM; g++) begin : g_line
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic [STAGES-1:0] sync_d;

    always_comb begin
      sync_d = {sync_q[STAGES-2:0], async_i[g]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        prev_q <= sync_q[STAGES-1];
      end
    end

    assign level_o[g]  = sync_q[STAGES-1];
    assign toggle_o[g] = sync_q[STAGES-1] ^ prev_q;
  end

endmodule

// File: rtl/tag_level_classify.sv
module tag_level_classify
  import tag_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int FULL_SCALE = 32768,
  parameter int TH_LO = 29205,
  parameter int TH_HI = 36766
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  output band_e               band_o
);

  localparam int MAG_W = SAMPLE_W + 1;
  localparam logic [MAG_W-1:0] LO_LIM = MAG_W'(TH_LO);
  localparam logic [MAG_W-1:0] FS_LIM = MAG_W'(FULL_SCALE);
  localparam logic [MAG_W-1:0] HI_LIM = MAG_W'(TH_HI);

  logic [MAG_W-1:0] ext;
  logic [MAG_W-1:0] neg;
  logic [MAG_W-1:0] mag;

  always_comb begin
    ext = {sample_i[SAMPLE_W-1], sample_i};
    neg = '0 - ext;
    mag = sample_i[SAMPLE_W-1] ? neg : ext;
    if (mag < LO_LIM) begin
      band_o = BAND_LOW;
    end else if (mag <= FS_LIM) begin
      band_o = BAND_NEAR;
    end else if (mag <= HI_LIM) begin
      band_o = BAND_OVER;
    end else begin
      band_o = BAND_CLIP;
    end
  end

endmodule

// File: rtl/tag_serializer.sv
module tag_serializer
  import tag_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lr_edge_i,
  input  logic       lr_level_i,
  input  logic       bclk_fall_i,
  input  logic [1:0] code_left_i,
  input  logic [1:0] code_right_i,
  output logic       tag_o
);

  ser_state_e state_q, state_d;
  logic [1:0] snap_q, snap_d;
  logic       tag_q, tag_d;

  always_comb begin
    state_d = state_q;
    snap_d  = snap_q;
    tag_d   = tag_q;
    if (lr_edge_i) begin
      state_d = S_ARMED;
      snap_d  = lr_level_i ? code_right_i : code_left_i;
      tag_d   = 1'b0;
    end else if (bclk_fall_i) begin
      case (state_q)
        S_ARMED: begin
          state_d = S_MSB;
          tag_d   = snap_q[1];
        end
        S_MSB: begin
          state_d = S_LSB;
          tag_d   = snap_q[0];
        end
        S_LSB: begin
          state_d = S_IDLE;
          tag_d   = 1'b0;
        end
        default: begin
          state_d = S_IDLE;
          tag_d   = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      snap_q  <= 2'b00;
      tag_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      snap_q  <= snap_d;
      tag_q   <= tag_d;
    end
  end

  assign tag_o = tag_q;

  // R7: bit 0 always follows bit 1 on the next launch edge
  p_lsb_follows_msb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MSB && bclk_fall_i && !lr_edge_i) |=> (state_q == S_LSB));

  // R11: the captured code holds until the next frame-clock transition
  p_snap_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lr_edge_i) |=> $stable(snap_q));

  // R9: the pin is low outside the two bit slots
  p_quiet_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lr_edge_i || (bclk_fall_i && state_q == S_LSB)) |=> !tag_q);

endmodule

// File: rtl/tag_overrange_encoder.sv
module tag_overrange_encoder
  import tag_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int FULL_SCALE  = 32768,
  parameter int TH_LO       = 29205,
  parameter int TH_HI       = 36766,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                left_stb_i,
  input  logic                right_stb_i,
  input  logic                lrck_i,
  input  logic                bclk_i,
  output logic                tag_o
);

  localparam int NUM_CH = 2;
  localparam int LINE_LR = 0;
  localparam int LINE_BC = 1;
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic        rst_n;
  logic [1:0]  lines;
  logic [1:0]  level;
  logic [1:0]  toggle;
  logic        lr_edge;
  logic        bclk_fall;
  band_e       band;
  logic [NUM_CH-1:0] stb;
  logic [1:0]  pend_q [NUM_CH];

  tag_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  assign lines[LINE_LR] = lrck_i;
  assign lines[LINE_BC] = bclk_i;

  tag_edge_detect #(.NUM(2), .STAGES(SYNC_STAGES)) u_edges (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (lines),
    .level_o (level),
    .toggle_o(toggle)
  );

  assign lr_edge   = toggle[LINE_LR];
  assign bclk_fall = toggle[LINE_BC] & ~level[LINE_BC];

  tag_level_classify #(
    .SAMPLE_W  (SAMPLE_W),
    .FULL_SCALE(FULL_SCALE),
    .TH_LO     (TH_LO),
    .TH_HI     (TH_HI)
  ) u_class (
    .sample_i(sample_i),
    .band_o  (band)
  );

  assign stb[0] = left_stb_i;
  assign stb[1] = right_stb_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [1:0] pend_d;
    always_comb begin
      pend_d = pend_q[c];
      if (stb[c]) begin
        pend_d = band;
      end
    end
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[c] <= 2'b00;
      end else begin
        pend_q[c] <= pend_d;
      end
    end
  end

  tag_serializer u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .lr_edge_i   (lr_edge),
    .lr_level_i  (level[LINE_LR]),
    .bclk_fall_i (bclk_fall),
    .code_left_i (pend_q[0]),
    .code_right_i(pend_q[1]),
    .tag_o       (tag_o)
  );

  // R5: the most negative input grades as the top band
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (left_stb_i && sample_i == MOST_NEG) |=> (pend_q[0] == 2'b11));

  // R10: a stored code moves only with a strobe for its channel
  p_hold_without_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!right_stb_i) |=> $stable(pend_q[1]));

  // R9: the pin moves only on a launch edge or a frame transition
  p_move_on_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tag_o != $past(tag_o)) |-> $past(bclk_fall || lr_edge));

endmodule

// File: tb/tag_overrange_encoder_tb.sv
module tag_overrange_encoder_tb;

  logic               clk = 1'b0;
  logic               rst_n;
  logic signed [19:0] sample;
  logic               lstb, rstb;
  logic               lrck, bclk;
  logic               tag;

  always #2 clk = ~clk;

  tag_overrange_encoder u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sample_i   (sample),
    .left_stb_i (lstb),
    .right_stb_i(rstb),
    .lrck_i     (lrck),
    .bclk_i     (bclk),
    .tag_o      (tag)
  );

  typedef struct {
    int    code;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  int   cur_half, cur_bit;
  int   vi = 0;
  event ev_fall, ev_load;

  localparam int NV = 11;
  int vec_l [NV] = '{0, 29204, 32768, 36766, -29204, -32768, -36766, -524288, -1, 100, 100000};
  int vec_r [NV] = '{1000, 29205, 32769, 36767, -29205, -32769, -36767, 524287, 12345, 30000, -100000};
  localparam int STICKY_IDX = 9;

  function automatic int grade(int v);
    int m;
    m = (v < 0) ? -v : v;
    if (m < 29205) return 0;
    if (m <= 32768) return 1;
    if (m <= 36766) return 2;
    return 3;
  endfunction

  function automatic string band_req(int v);
    string s;
    case (grade(v))
      0: s = "R2";
      1: s = "R3";
      2: s = "R4";
      default: s = "R5";
    endcase
    if (v < 0) s = {s, "/R6"};
    return s;
  endfunction

  task automatic check(input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: tag actual %0b expected %0b", what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: load the next pair after the right tag has been captured
  initial begin
    forever begin
      @(ev_load);
      if (vi < NV) begin
        exp_t el, er;
        repeat (2) @(negedge clk);
        if (vi == STICKY_IDX) begin
          sample = 20'(40000);
          lstb = 1'b1;
          @(negedge clk);
        end
        sample = 20'(vec_l[vi]);
        lstb = 1'b1;
        @(negedge clk);
        lstb = 1'b0;
        sample = 20'(vec_r[vi]);
        rstb = 1'b1;
        @(negedge clk);
        rstb = 1'b0;
        el.code = grade(vec_l[vi]);
        el.req  = band_req(vec_l[vi]);
        er.code = grade(vec_r[vi]);
        er.req  = {band_req(vec_r[vi]), "/R11"};
        if (vi == STICKY_IDX) el.req = {el.req, "/R10"};
        q.push_back(el);
        q.push_back(er);
        vi++;
      end
    end
  end

  // Monitor: two samples per bit slot, away from the launch edge
  initial begin
    exp_t cur;
    cur.code = 0;
    cur.req  = "R1";
    forever begin
      int h, b;
      logic expv;
      string what;
      @(ev_fall);
      h = cur_half;
      b = cur_bit;
      if (b == 0) begin
        if (q.size() > 0) cur = q.pop_front();
      end
      if (b == 1) begin
        expv = cur.code[1];
        what = $sformatf("%s/R7/R8 %s bit1", cur.req, h ? "right" : "left");
      end else if (b == 2) begin
        expv = cur.code[0];
        what = $sformatf("%s/R7/R8 %s bit0", cur.req, h ? "right" : "left");
      end else begin
        expv = 1'b0;
        what = $sformatf("R9 idle slot %0d", b);
      end
      repeat (10) @(negedge clk);
      check(tag, expv, what);
      repeat (5) @(negedge clk);
      check(tag, expv, {what, " held"});
    end
  end

  task automatic run_frames(input int n);
    for (int f = 0; f < n; f++) begin
      for (int h = 0; h < 2; h++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          bclk = 1'b0;
          if (b == 0) lrck = (h == 1);
          cur_half = h;
          cur_bit  = b;
          ->ev_fall;
          if (h == 1 && b == 1) ->ev_load;
          repeat (8) @(negedge clk);
          bclk = 1'b1;
          repeat (7) @(negedge clk);
        end
      end
    end
  endtask

  task automatic seed_zero();
    exp_t z;
    q.delete();
    z.code = 0;
    z.req  = "R1";
    q.push_back(z);
    q.push_back(z);
  endtask

  initial begin
    rst_n  = 1'b0;
    sample = '0;
    lstb   = 1'b0;
    rstb   = 1'b0;
    lrck   = 1'b1;
    bclk   = 1'b1;
    repeat (4) @(negedge clk);
    check(tag, 1'b0, "R1 tag low in reset");
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(tag, 1'b0, "R1 tag low before first frame");
    seed_zero();
    run_frames(NV + 1);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    bclk = 1'b0;
    repeat (3) @(negedge clk);
    check(tag, 1'b0, "R1 tag low in second reset");
    bclk = 1'b1;
    lrck = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    seed_zero();
    run_frames(1);
    repeat (20) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule